// File: doc/BRIEF.md
# Prioritized Pin-Function Port Controller

This block manages a small bidirectional I/O port in which every pin has three possible owners. A pulse-width modulator channel takes a pin as soon as that channel is enabled. If the channel is off and the routed serial peripheral interface is switched on, that interface takes the pin. If neither alternate function is active, the pin is plain general-purpose I/O, and two registers control it: a latched output value and a direction mask. The serial signals are assigned to pins in a fixed order. Pin 0 carries MISO, pin 1 carries MOSI, pin 2 carries the serial clock and pin 3 carries slave select.

Software reaches the port through a small synchronous register file. Each pin input passes through a two-flop synchronizer. A read of the data register returns the latched value for output pins and the synchronized pin level for input pins. A separate read-only register always returns the synchronized pin levels. A write to the data register always updates the latch, even while an alternate function owns the pin. The new value reaches the pad once the pin returns to general-purpose use.

Top module: `pinmux_port`

## Requirements
- R1: After reset the data latch and the direction mask are both 0. Every pin then has its output enable low, and reads of the data register (address 0) and the direction register (address 1) return 0.
- R2: When `pwm_en[i]` is 1, `pin_out[i]` equals `pwm_out[i]` and `pin_oe[i]` is 1, whatever the serial and general-purpose settings.
- R3: When `pwm_en[i]` is 0 and `spi_en` is 1, the serial interface owns pin i. The pin then carries that pin's serial signal (0 MISO, 1 MOSI, 2 SCK, 3 SS). The enable for pin 0 is `!spi_master`, and the enable for pins 1 to 3 is `spi_master`.
- R4: When neither alternate function owns pin i, `pin_out[i]` is data-latch bit i and `pin_oe[i]` is direction bit i.
- R5: A read of the data register (address 0) returns, in bit i, the latch bit when direction bit i is 1, and otherwise the synchronized pin level.
- R6: The input register (address 2) always returns the synchronized pin levels. A write to address 2 changes no register.
- R7: A pin change appears in register reads on the second clock edge after it is applied. Read data is registered, so it is valid on the edge after the edge at which the address was presented.
- R8: A write to the data register updates the latch even while an alternate function owns the pin. The value appears on `pin_out` once ownership returns to general-purpose use.
- R9: Only bits [3:0] of each register exist. Read bits [7:4] are always 0, and reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 input) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_en | input | 4 | Per-channel PWM enable |
| pwm_out | input | 4 | Per-channel PWM output level |
| spi_en | input | 1 | Routed serial interface enable |
| spi_master | input | 1 | 1 when the serial interface is master |
| spi_miso_o | input | 1 | MISO value driven in slave mode |
| spi_mosi_o | input | 1 | MOSI value driven in master mode |
| spi_sck_o | input | 1 | Clock value driven in master mode |
| spi_ss_o | input | 1 | Slave-select value driven in master mode |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |
| pin_sync | output | 4 | Synchronized pin levels, for the serial receiver |

## Verification
The bench builds the block with its default four-pin width and a two-stage synchronizer. This keeps all sixteen combinations of PWM enable and direction within reach of random stimulus. It also makes the two-edge input delay a fixed number of cycles that the bench can count.

The bench runs random rounds of enables, serial mode, pin levels and register writes. Each round is compared against a bench-side model of the ownership priority and the read multiplexer. Directed cases cover three situations:
- writes to the read-only register;
- writes to the latch while PWM owns a pin, followed by release of that pin;
- reads of the upper bits and of the unused address.

// File: rtl/pinmux_pkg.sv
// Package: shared constants and the owner encoding for the pin-function port.
// Assumes: an 8-bit register bus with a 2-bit address.
package pinmux_pkg;
    localparam int BUS_W = 8;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_IN   = 2'd2;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_SPI  = 2'd1,
        OWN_PWM  = 2'd2
    } owner_e;
endpackage

// File: rtl/pin_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes: pad inputs are asynchronous. The reset leaves the chain as it is,
// so the chain simply tracks the pins.
module pin_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        chain[0] <= d;
        for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_arbiter.sv
// Module: resolves the owner of one pin (PWM over serial over GPIO) and
// drives that pin's output value and output enable.
// Assumes: the alternate-function signal and its direction are already
// chosen for this pin.
module pin_arbiter
    import pinmux_pkg::*;
(
    input  logic pwm_en,
    input  logic pwm_val,
    input  logic spi_en,
    input  logic spi_val,
    input  logic spi_drive,
    input  logic gpio_val,
    input  logic gpio_dir,
    output logic out_val,
    output logic out_en
);
    owner_e owner;

    // Choose the owner by fixed priority.
    always_comb begin
        if (pwm_en)      owner = OWN_PWM;
        else if (spi_en) owner = OWN_SPI;
        else             owner = OWN_GPIO;
    end

    // Route the owner's value and enable to the pad.
    always_comb begin
        unique case (owner)
            OWN_PWM: begin out_val = pwm_val; out_en = 1'b1;      end
            OWN_SPI: begin out_val = spi_val; out_en = spi_drive; end
            default: begin out_val = gpio_val; out_en = gpio_dir; end
        endcase
    end

    always_comb begin
        AST_PWM_WINS: assert (!pwm_en || (out_en && out_val == pwm_val)); // R2
        AST_SPI_NEXT: assert (pwm_en || !spi_en || (out_en == spi_drive && out_val == spi_val)); // R3
    end
endmodule

// File: rtl/port_regs.sv
// Module: data latch, direction mask and registered read multiplexer.
// Assumes: a single-cycle synchronous bus; only the low PINS bits exist.
module port_regs
    import pinmux_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [PINS-1:0]   pins_s,
    output logic [BUS_W-1:0]  rdata,
    output logic [PINS-1:0]   data_q,
    output logic [PINS-1:0]   dir_q
);
    localparam int PAD = BUS_W - PINS;
    logic [PINS-1:0] rd_next;

    // Write the data latch and the direction mask; address 2 is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (we) begin
            if (addr == ADR_DATA) data_q <= wdata[PINS-1:0];
            if (addr == ADR_DIR)  dir_q  <= wdata[PINS-1:0];
        end
    end

    // Select the read value; on address 0 each direction bit picks latch or pin.
    always_comb begin
        case (addr)
            ADR_DATA: rd_next = (data_q & dir_q) | (pins_s & ~dir_q);
            ADR_DIR:  rd_next = dir_q;
            ADR_IN:   rd_next = pins_s;
            default:  rd_next = '0;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= {{PAD{1'b0}}, rd_next};
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (data_q == '0 && dir_q == '0)); // R1
    AST_IN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_IN) |=> ($stable(data_q) && $stable(dir_q))); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:PINS] == '0); // R9
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_DATA) |=> data_q == $past(wdata[PINS-1:0])); // R8
endmodule

// File: rtl/pinmux_port.sv
// Module: top of the four-pin port with prioritized function ownership.
// Assumes: serial signal order per pin is MISO, MOSI, SCK, SS for pins 0..3;
// MISO is driven in slave mode, the other three in master mode.
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [3:0]        pwm_en,
    input  logic [3:0]        pwm_out,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              spi_miso_o,
    input  logic              spi_mosi_o,
    input  logic              spi_sck_o,
    input  logic              spi_ss_o,
    input  logic [3:0]        pin_in,
    output logic [3:0]        pin_out,
    output logic [3:0]        pin_oe,
    output logic [3:0]        pin_sync
);
    localparam int PINS = 4;
    logic [PINS-1:0] data_q, dir_q, spi_val, spi_drv;

    // Map the serial signals and their directions onto the pins.
    always_comb begin
        spi_val = {spi_ss_o, spi_sck_o, spi_mosi_o, spi_miso_o};
        spi_drv = {spi_master, spi_master, spi_master, !spi_master};
    end

    pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .d(pin_in), .q(pin_sync)
    );

    port_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .pins_s(pin_sync), .rdata(bus_rdata),
        .data_q(data_q), .dir_q(dir_q)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_arbiter u_arb (
            .pwm_en(pwm_en[i]), .pwm_val(pwm_out[i]), .spi_en(spi_en),
            .spi_val(spi_val[i]), .spi_drive(spi_drv[i]),
            .gpio_val(data_q[i]), .gpio_dir(dir_q[i]),
            .out_val(pin_out[i]), .out_en(pin_oe[i])
        );
    end

    AST_GPIO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en == '0 && !spi_en) |-> (pin_out == data_q && pin_oe == dir_q)); // R4
endmodule

// File: tb/pinmux_port_test.sv
module pinmux_port_test;
    logic clk = 0, rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic bus_we = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [3:0] pwm_en = 0, pwm_out = 0, pin_in = 0, pin_out, pin_oe, pin_sync;
    logic spi_en = 0, spi_master = 0, miso = 0, mosi = 0, sck = 0, ss = 0;
    int checks = 0, fails = 0;
    logic [3:0] m_data = 0, m_dir = 0;

    always #4 clk = ~clk;

    pinmux_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
        .pwm_out(pwm_out), .spi_en(spi_en), .spi_master(spi_master),
        .spi_miso_o(miso), .spi_mosi_o(mosi), .spi_sck_o(sck), .spi_ss_o(ss),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_sync(pin_sync)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_out(input logic [3:0] d);
        logic [3:0] sv = {ss, sck, mosi, miso};
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = pwm_en[i] ? pwm_out[i] : spi_en ? sv[i] : d[i];
        return {4'h0, r};
    endfunction

    function automatic logic [7:0] exp_oe(input logic [3:0] dr);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = pwm_en[i] ? 1'b1 : spi_en ? (i == 0 ? !spi_master : spi_master) : dr[i];
        return {4'h0, r};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0;
        if (a == 0) m_data = d[3:0];
        if (a == 1) m_dir = d[3:0];
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_we = 0;
        @(posedge clk); #1;
        v = bus_rdata;
    endtask

    task automatic settle_pins(input logic [3:0] p);
        pin_in = p;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 oe", {4'h0, pin_oe}, 8'h00);
        rd(0, v); check("R1 data", v, 8'h00);
        rd(1, v); check("R1 dir", v, 8'h00);
        rst_n = 1;

        // R7: the pin change is visible after exactly two edges.
        settle_pins(4'h0);
        pin_in = 4'hA; bus_addr = 2;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R7 sync edge2 rdata", bus_rdata, 8'h00);
        @(posedge clk); #1;
        check("R7 read after sync", bus_rdata, 8'h0A);

        // R6: a write to the input register changes neither register.
        wr(1, 8'h05); wr(0, 8'h03);
        wr(2, 8'hFF);
        rd(0, v); check("R6 data kept", v, 8'h0B);
        rd(1, v); check("R6 dir kept", v, 8'h05);
        rd(2, v); check("R6 input", v, 8'h0A);

        // R9: the upper bits and the unused address read as 0.
        wr(1, 8'hFF);
        rd(1, v); check("R9 upper", v, 8'h0F);
        rd(3, v); check("R9 unused", v, 8'h00);

        // R8: write the latch under PWM ownership, then release the pin.
        pwm_en = 4'hF; pwm_out = 4'h5; #1;
        wr(0, 8'h0C);
        check("R8 pwm owns", {4'h0, pin_out}, 8'h05);
        pwm_en = 4'h0; #1;
        check("R8 latched shows", {4'h0, pin_out}, 8'h0C);

        // Random rounds covering R2, R3, R4 and R5.
        for (int k = 0; k < 300; k++) begin
            pwm_en = $urandom; pwm_out = $urandom;
            spi_en = $urandom; spi_master = $urandom;
            {miso, mosi, sck, ss} = 4'($urandom);
            if (k % 3 == 0) wr(0, 8'($urandom));
            if (k % 4 == 0) wr(1, 8'($urandom));
            settle_pins(4'($urandom));
            #1;
            check("R2 R3 R4 out", {4'h0, pin_out}, exp_out(m_data));
            check("R2 R3 R4 oe", {4'h0, pin_oe}, exp_oe(m_dir));
            rd(0, v);
            check("R5 data read", v, {4'h0, (m_data & m_dir) | (pin_in & ~m_dir)});
            rd(2, v);
            check("R6 input read", v, {4'h0, pin_in});
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule